// File: doc/BRIEF.md
# SPI Slave Engine with Select-Loss Fault Detection

This block is the receive/transmit engine of a serial peripheral port that only ever plays the slave role. An external master drives the select, the serial clock and the master-out data line. The block shifts one 8-bit byte in each direction per transfer, most significant bit first. It drives the slave-out data line together with a separate output enable, so that pad logic can float the line while the slave is not selected. Clock polarity and clock phase are programmable, which covers all four SPI modes.

A small register port gives a processor access to a configuration register, a flag register and a data location. Writes to the data location go to the transmit holding register, and reads come from the receive register. The engine flags a fault when the master releases the select line in the middle of a byte. This flag has a guarded two-step clear. Three level interrupt requests are built from the flags: transmit, receive, and receive/error. All three external serial inputs pass through two-flop synchronisers, and every edge is detected in the system clock domain.

Top module: `spi_slave_mf`

## Requirements
- R1: After reset, the configuration register (regSel 0) reads 0x00, the flag register (regSel 1) reads 0x01, misoOe is 0 and all three interrupt requests are 0. Configuration bits: bit0 enable, bit1 cpha, bit2 cpol, bit3 txIe, bit4 rxIe, bit5 errIe. Flag bits: bit0 txEmpty, bit1 rxFull, bit2 overrun, bit3 modeFault. regSel 2 is the data location.
- R2: In each of the four cpol/cpha modes, a complete 8-bit transfer returns the transmit byte MSB first on misoOut. The byte received on mosi then reads back from the data location, and rxFull sets.
- R3: With cpha = 0, the falling of the select line starts the transfer: the MSB of the transmit byte appears on misoOut before any serial clock edge.
- R4: misoOe is 1 only while the block is enabled and selected. While the select line is high, clock edges are ignored, and a byte that was partly shifted is dropped without setting rxFull.
- R5: modeFault sets when the select line rises after a transfer has started but before its eighth bit. A transfer starts at the select falling for cpha = 0 and at the first clock edge for cpha = 1. Selecting and deselecting without any clock edge under cpha = 1 leaves modeFault at 0.
- R6: Setting modeFault leaves the configuration register, including enable, unchanged. After an aborted byte, the next transfer completes normally.
- R7: modeFault clears only when the flag register is read while modeFault is 1 and a configuration write follows. The write does not clear it if a new fault is detected in the same cycle, and a configuration write with no prior read does not clear it.
- R8: A byte that completes while rxFull is 1 is discarded: the data location keeps the earlier byte and overrun sets. overrun clears when the flag register is read with overrun set and the data location is read after that.
- R9: Reading the data location clears rxFull. Writing it clears txEmpty, and txEmpty sets again when the written byte is loaded into the shift register at the start of a transfer.
- R10: txIrq = txEmpty and txIe and enable; rxIrq = rxFull and rxIe; errIrq = errIe and (overrun or modeFault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selN | input | 1 | Slave select from the master, active low |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Master-out serial data |
| misoOut | output | 1 | Slave-out serial data |
| misoOe | output | 1 | Output enable for misoOut (0 = float) |
| regSel | input | 2 | Register select: 0 config, 1 flags, 2 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (applies read side effects) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Receive/error interrupt request |

## Verification
On every cycle, the assertions check the following. A byte is loaded only into an idle engine, and a deselected engine drops to idle on the next cycle. A completion never coincides with a fault. A fault arriving during the clearing write leaves the flag set. An overrun leaves the received byte untouched. A load refills txEmpty, and only a configuration write changes the configuration. The bench scenarios show the end-to-end behaviour: the serial bit order in all four modes, MISO presenting the MSB before the first clock, the absence of a fault for a clockless cpha = 1 selection, the two-step clear sequences for modeFault and overrun, and the interrupt levels.

// File: rtl/spi_slave_pkg.sv
`timescale 1ns/1ps
package spi_slave_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // configuration register, bit0 = enable ... bit5 = errIe
  typedef struct packed {
    logic errIe;
    logic rxIe;
    logic txIe;
    logic cpol;
    logic cpha;
    logic enable;
  } ctrlReg_t;

  // strobes from the serial control to the datapath
  typedef struct packed {
    logic loadTx;
    logic shiftOut;
    logic sampleIn;
    logic complete;
    logic fault;
  } engStrobe_t;
endpackage

// File: rtl/spi_slave_ctrl.sv
`timescale 1ns/1ps
module spi_slave_ctrl
  import spi_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       enable,
  input  logic       cpha,
  input  logic       cpol,
  output engStrobe_t stb,
  output logic       selected,
  output logic       mosiBit
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] selPipe, sclkPipe, mosiPipe;
  logic selS, sclkS, selPrev, sclkPrev;
  logic sclkRise, sclkFall, leadEdge, trailEdge, selFall, selRise;
  logic active;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPipe  <= '1;
      sclkPipe <= '0;
      mosiPipe <= '0;
      selPrev  <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      selPipe  <= {selPipe[SYNC_STAGES-2:0], selN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      selPrev  <= selS;
      sclkPrev <= sclkS;
    end
  end

  assign selS    = selPipe[SYNC_STAGES-1];
  assign sclkS   = sclkPipe[SYNC_STAGES-1];
  assign mosiBit = mosiPipe[SYNC_STAGES-1];

  assign sclkRise  = sclkS & ~sclkPrev;
  assign sclkFall  = ~sclkS & sclkPrev;
  assign leadEdge  = cpol ? sclkFall : sclkRise;
  assign trailEdge = cpol ? sclkRise : sclkFall;
  assign selFall   = ~selS & selPrev;
  assign selRise   = selS & ~selPrev;
  assign selected  = enable & ~selS;

  always_comb begin
    stb.loadTx   = enable & ((~cpha & selFall) | (cpha & ~selS & ~active & leadEdge));
    stb.sampleIn = enable & active & ~selS & (cpha ? trailEdge : leadEdge);
    stb.shiftOut = enable & active & ~selS & (cpha ? leadEdge : trailEdge);
    stb.complete = stb.sampleIn & (bitCnt == LAST_BIT);
    stb.fault    = enable & active & selRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else begin
      if (!enable || stb.fault || stb.complete) active <= 1'b0;
      else if (stb.loadTx)                      active <= 1'b1;
      if (stb.loadTx || stb.complete || !enable) bitCnt <= '0;
      else if (stb.sampleIn)                     bitCnt <= bitCnt + 1'b1;
    end
  end

  // R3: a byte is only loaded into an idle engine
  p_load_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |-> !active);
  // R4: a deselected engine is idle on the next cycle
  p_deselect_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    selS |=> !active);
  // R5: a completed byte is never also a fault
  p_done_not_fault_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.complete && stb.fault));
endmodule

// File: rtl/spi_slave_dp.sv
`timescale 1ns/1ps
module spi_slave_dp
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        stb,
  input  logic              mosiBit,
  input  logic              selected,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output ctrlReg_t          cfg,
  output logic              misoOut,
  output logic              misoOe,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              errIrq
);
  localparam int CFG_W = $bits(ctrlReg_t);

  logic [DATA_W-1:0] txShift, rxShift, txData, rxData, rxByte;
  ctrlReg_t ctrlQ;
  logic txEmpty, rxFull, ovr, modeFault, mfArmed, ovrArmed;
  logic wrCtrl, wrTx, rdStat, rdRx;

  assign wrCtrl = regWr & (regSel == ADDR_CTRL);
  assign wrTx   = regWr & (regSel == ADDR_DATA);
  assign rdStat = regRd & (regSel == ADDR_STAT);
  assign rdRx   = regRd & (regSel == ADDR_DATA);
  assign rxByte = {rxShift[DATA_W-2:0], mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (stb.loadTx)        txShift <= txData;
      else if (stb.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (stb.sampleIn)      rxShift <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      txData    <= '0;
      rxData    <= '0;
      txEmpty   <= 1'b1;
      rxFull    <= 1'b0;
      ovr       <= 1'b0;
      modeFault <= 1'b0;
      mfArmed   <= 1'b0;
      ovrArmed  <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= wrData[CFG_W-1:0];
      if (wrTx) begin
        txData  <= wrData;
        txEmpty <= 1'b0;
      end else if (stb.loadTx) begin
        txEmpty <= 1'b1;
      end
      // receive and overrun
      if (stb.complete && rxFull) begin
        ovr <= 1'b1;
      end else begin
        if (stb.complete) begin
          rxData <= rxByte;
          rxFull <= 1'b1;
        end else if (rdRx) begin
          rxFull <= 1'b0;
        end
        if (rdRx && ovrArmed) ovr <= 1'b0;
      end
      if (rdStat && ovr) ovrArmed <= 1'b1;
      else if (rdRx)     ovrArmed <= 1'b0;
      // mode fault with guarded clear
      if (stb.fault)                 modeFault <= 1'b1;
      else if (wrCtrl && mfArmed)    modeFault <= 1'b0;
      if (rdStat && modeFault)       mfArmed <= 1'b1;
      else if (wrCtrl)               mfArmed <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      ADDR_CTRL: rdData[CFG_W-1:0] = ctrlQ;
      ADDR_STAT: rdData[3:0] = {modeFault, ovr, rxFull, txEmpty};
      ADDR_DATA: rdData = rxData;
      default:   rdData = '0;
    endcase
  end

  assign cfg     = ctrlQ;
  assign misoOe  = selected;
  assign misoOut = selected & txShift[DATA_W-1];
  assign txIrq   = txEmpty & ctrlQ.txIe & ctrlQ.enable;
  assign rxIrq   = rxFull & ctrlQ.rxIe;
  assign errIrq  = ctrlQ.errIe & (ovr | modeFault);

  // R6: only a configuration write alters the configuration
  p_ctrl_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtrl |=> $stable(ctrlQ));
  // R7: a fault detected during the clearing write keeps the flag
  p_mf_guard_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.fault |=> modeFault);
  // R8: an overrun keeps the earlier byte
  p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.complete && rxFull) |=> (ovr && $stable(rxData)));
  // R9: loading the shift register refills txEmpty
  p_tx_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && !wrTx) |=> txEmpty);
endmodule

// File: rtl/spi_slave_mf.sv
`timescale 1ns/1ps
module spi_slave_mf
  import spi_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              misoOut,
  output logic              misoOe,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              errIrq
);
  engStrobe_t stb;
  ctrlReg_t   cfg;
  logic       selected, mosiBit;

  spi_slave_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .mosi(mosi),
    .enable(cfg.enable), .cpha(cfg.cpha), .cpol(cfg.cpol),
    .stb(stb), .selected(selected), .mosiBit(mosiBit)
  );

  spi_slave_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiBit(mosiBit), .selected(selected),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .wrData(wrData),
    .rdData(rdData), .cfg(cfg), .misoOut(misoOut), .misoOe(misoOe),
    .txIrq(txIrq), .rxIrq(rxIrq), .errIrq(errIrq)
  );
endmodule

// File: tb/spi_slave_mf_bench.sv
`timescale 1ns/1ps
module spi_slave_mf_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic selN = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic misoOut, misoOe, txIrq, rxIrq, errIrq;
  logic [1:0] regSel = 2'd0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] wrData = 8'd0, rdData;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_slave_mf u_spi_slave_mf (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .mosi(mosi),
    .misoOut(misoOut), .misoOe(misoOe), .regSel(regSel), .regWr(regWr),
    .regRd(regRd), .wrData(wrData), .rdData(rdData),
    .txIrq(txIrq), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  // {cpol, cpha, txByte, mosiByte}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 8'h01, 8'h80},
    {1'b1, 1'b1, 8'hFF, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (8) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regSel = a; wrData = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regSel = a; regRd = 1'b1; #1 d = rdData;
    @(negedge clk); regRd = 1'b0;
  endtask

  // master drives nbits bits; selection handled by caller
  task automatic spiBits(input logic cpol, input logic cpha, input logic [7:0] mb,
                         input int nbits, output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        mosi = mb[7-i]; waitH();
        got = {got[6:0], misoOut};
        sclk = ~cpol; waitH();
        sclk = cpol;
      end else begin
        sclk = ~cpol; waitH();
        mosi = mb[7-i];
        got = {got[6:0], misoOut};
        sclk = cpol; waitH();
      end
    end
    waitH();
  endtask

  task automatic fullXfer(input logic cpol, input logic cpha, input logic [7:0] mb,
                          output logic [7:0] got);
    sclk = cpol; selN = 1'b0; waitH();
    spiBits(cpol, cpha, mb, 8, got);
    selN = 1'b1; waitH();
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] d, got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regRead(2'd0, d); check("R1 ctrl", d, 8'h00);
    regRead(2'd1, d); check("R1 status", d, 8'h01);
    check("R1 misoOe", {7'd0, misoOe}, 8'h00);
    check("R1 irqs", {5'd0, txIrq, rxIrq, errIrq}, 8'h00);

    // R2 table of transfers across all modes
    foreach (VEC[k]) begin
      sclk = VEC[k][17];
      regWrite(2'd0, {5'd0, VEC[k][17], VEC[k][16], 1'b1});
      regWrite(2'd2, VEC[k][15:8]);
      fullXfer(VEC[k][17], VEC[k][16], VEC[k][7:0], got);
      check("R2 miso byte", got, VEC[k][15:8]);
      check("R4 oe off after deselect", {7'd0, misoOe}, 8'h00);
      regRead(2'd1, d); check("R2 rxFull", d, 8'h03);
      regRead(2'd2, d); check("R2 rx byte", d, VEC[k][7:0]);
      regRead(2'd1, d); check("R9 rxFull cleared", d, 8'h01);
    end

    // R9/R10/R3/R4: tx empty, tx irq, MSB before clock, oe while selected
    sclk = 1'b0;
    regWrite(2'd0, 8'h09);
    check("R10 txIrq empty", {7'd0, txIrq}, 8'h01);
    regWrite(2'd2, 8'hC3);
    check("R10 txIrq full", {7'd0, txIrq}, 8'h00);
    regRead(2'd1, d); check("R9 txEmpty cleared", d, 8'h00);
    selN = 1'b0; waitH();
    check("R3 msb before clock", {7'd0, misoOut}, 8'h01);
    check("R4 oe selected", {7'd0, misoOe}, 8'h01);
    check("R9 txEmpty after load", {7'd0, txIrq}, 8'h01);
    spiBits(1'b0, 1'b0, 8'h11, 8, got);
    selN = 1'b1; waitH();
    check("R3 byte", got, 8'hC3);
    regRead(2'd2, d); check("R9 rx", d, 8'h11);
    regWrite(2'd0, 8'h08);
    check("R10 txIrq disabled", {7'd0, txIrq}, 8'h00);

    // R10 rx irq
    regWrite(2'd0, 8'h11);
    fullXfer(1'b0, 1'b0, 8'h6B, got);
    check("R10 rxIrq set", {7'd0, rxIrq}, 8'h01);
    regRead(2'd2, d);
    check("R10 rxIrq cleared", {7'd0, rxIrq}, 8'h00);

    // R5/R4/R6/R7 mode fault mid byte
    regWrite(2'd0, 8'h21);
    sclk = 1'b0; selN = 1'b0; waitH();
    spiBits(1'b0, 1'b0, 8'hE7, 3, got);
    selN = 1'b1; waitH();
    check("R10 errIrq", {7'd0, errIrq}, 8'h01);
    check("R4 oe off", {7'd0, misoOe}, 8'h00);
    regWrite(2'd0, 8'h21);
    regRead(2'd1, d); check("R7 no clear without read", d, 8'h09);
    regRead(2'd0, d); check("R6 config kept", d, 8'h21);
    regWrite(2'd0, 8'h21);
    regRead(2'd1, d); check("R7 cleared", d, 8'h01);
    check("R10 errIrq cleared", {7'd0, errIrq}, 8'h00);
    regWrite(2'd2, 8'h96);
    fullXfer(1'b0, 1'b0, 8'h2D, got);
    check("R6 next byte out", got, 8'h96);
    regRead(2'd2, d); check("R6 next byte in", d, 8'h2D);

    // R7 fault coinciding with clearing write
    selN = 1'b0; waitH(); spiBits(1'b0, 1'b0, 8'h00, 2, got);
    selN = 1'b1; waitH();
    regRead(2'd1, d); check("R5 fault set", d, 8'h09);
    selN = 1'b0; waitH();
    @(negedge clk); selN = 1'b1;
    @(negedge clk);
    @(negedge clk); regSel = 2'd0; wrData = 8'h21; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
    waitH();
    regRead(2'd1, d); check("R7 kept on coincident fault", d, 8'h09);
    regWrite(2'd0, 8'h21);
    regRead(2'd1, d); check("R7 cleared after", d, 8'h01);

    // R5 cpha=1 select without clock
    regWrite(2'd0, 8'h03);
    sclk = 1'b0; selN = 1'b0; waitH(); selN = 1'b1; waitH();
    regRead(2'd1, d); check("R5 no fault cpha1", d, 8'h01);

    // R8 overrun
    regWrite(2'd0, 8'h01);
    regWrite(2'd2, 8'hA5);
    fullXfer(1'b0, 1'b0, 8'h3C, got);
    fullXfer(1'b0, 1'b0, 8'h77, got);
    regRead(2'd1, d); check("R8 overrun flags", d, 8'h07);
    regRead(2'd2, d); check("R8 first byte kept", d, 8'h3C);
    regRead(2'd1, d); check("R8 overrun cleared", d, 8'h01);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule